// File: doc/BRIEF.md
# Free Label Stack with Background Refill

This block holds the pool of unused object labels for a streaming component labeller. The label assigner pops a label whenever a new object starts. Labels released by merged objects come back through the push side at the end of each image line. The top of the stack is always the next label to hand out. When the stack is full, label 1 is on top, then 2, and so on up to the parameter `NUM_LABELS`.

At every frame boundary the pool must return to that full, ordered state. Rewriting every entry takes one cycle per label, which does not fit in vertical blanking. A pulse on `frame_start_i` therefore resets the stack pointer at once and starts a background refill. The refill writes one memory entry per free cycle. It starts at the top position and moves downward, and it keeps running into the next frame.

The memory has a single port, and requests share it in this priority order:

1. A pop takes the port first (operation PORT_READ), and the refill step is suspended in that cycle.
2. A deferred push is written next (PORT_FLUSH).
3. A new push follows (PORT_PUSH).
4. The refill writes only when nothing else wants the port (PORT_FILL). Otherwise the port is left unused (PORT_IDLE).

A pop that reaches an entry the refill has not rewritten yet returns the value the refill would have written there. When a push arrives in the same cycle as a memory read, it waits one cycle in a one-entry holding register, and that register is the logical top of the stack.

The control unit has two states:

- FILL_RUN: the refill is still pending. Power-on reset and `frame_start_i` both enter this state.
- FILL_DONE: the refill is complete. The unit moves from FILL_RUN to FILL_DONE once no entry below the top remains unwritten. This happens either because the last refill write has finished, or because pops have consumed the unwritten region.

Top module: `free_label_stack`

## Requirements
- R1: After reset or a frame start, successive pops return labels 1, 2, 3, … up to NUM_LABELS, in that order.
- R2: A pop accepted at a clock edge produces `lbl_vld_o` high for exactly the following cycle, with `lbl_o` holding the label that was on top before that edge.
- R3: A pushed label is the next label returned by a pop (last in, first out), and any number of pushes return in reverse order.
- R4: A pop from an empty stack returns label 0, and `empty_err_o` is high in the same cycle as `lbl_vld_o`.
- R5: `frame_start_i` restores the full initial contents regardless of earlier pops and pushes. A pop or push in the same cycle as `frame_start_i` is dropped, so no `lbl_vld_o` follows it.
- R6: `fill_busy_o` is high from the cycle after reset or a frame start. If no pops or pushes occur, it falls after exactly NUM_LABELS cycles, because the refill writes one entry per free cycle.
- R7: Pops issued while the refill is still running return the correct initial labels, including entries the refill has not rewritten yet.
- R8: When a pop and a push fall in the same cycle, the pop returns the previous top and the pushed label becomes the new top. The push is written to memory one cycle later, and it is served directly if a pop comes first.
- R9: A label pushed while the refill is running is kept and is not overwritten by later refill writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | One-cycle pulse that starts a frame and triggers the refill |
| pop_i | input | 1 | Request for a free label |
| push_i | input | 1 | Return of a recycled label |
| push_lbl_i | input | $clog2(NUM_LABELS+1) | Label being returned |
| lbl_o | output | $clog2(NUM_LABELS+1) | Popped label |
| lbl_vld_o | output | 1 | `lbl_o` is valid this cycle |
| empty_err_o | output | 1 | The pop found the stack empty |
| fill_busy_o | output | 1 | Background refill still running |

## Verification
The riskiest case is a pop that arrives straight after a frame start, before the refill has reached that entry. A design that read stale memory there would hand out labels left over from the previous frame. Pushes made during the refill are stored below entries the refill still plans to write. A design that skipped the clamping of the refill pointer would later overwrite them, so those labels would vanish and duplicates would appear. Same-cycle pop and push, with a follow-up pop in the next cycle, checks that the deferred label is neither lost nor returned twice. The empty pop and the exact cycle at which `fill_busy_o` falls check the edges of the stack depth and of the refill count.

// File: rtl/flstk_pkg.sv
package flstk_pkg;

    typedef enum logic [0:0] {
        FILL_RUN  = 1'b0,
        FILL_DONE = 1'b1
    } fill_st_t;

    typedef enum logic [2:0] {
        PORT_IDLE,
        PORT_READ,
        PORT_FLUSH,
        PORT_PUSH,
        PORT_FILL
    } port_op_t;

endpackage

// File: rtl/flstk_mem.sv
module flstk_mem #(
    parameter int DEPTH = 256,
    parameter int DW    = 9,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr_w,
    input  logic [DW-1:0] data_w,
    input  logic [AW-1:0] addr_r,
    output logic [DW-1:0] data_r
);

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr_w] <= data_w;
        end
    end

    assign data_r = cells[addr_r];

endmodule

// File: rtl/flstk_ctrl.sv
module flstk_ctrl
    import flstk_pkg::*;
#(
    parameter int NUM_LABELS = 256,
    parameter int LBL_W      = 9,
    parameter int AW         = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start_i,
    input  logic             pop_i,
    input  logic             push_i,
    input  logic [LBL_W-1:0] push_lbl_i,
    input  logic [LBL_W-1:0] mem_rdata,
    output logic             mem_we,
    output logic [AW-1:0]    mem_waddr,
    output logic [LBL_W-1:0] mem_wdata,
    output logic [AW-1:0]    mem_raddr,
    output logic [LBL_W-1:0] lbl_o,
    output logic             lbl_vld_o,
    output logic             empty_err_o,
    output logic             fill_busy_o
);

    localparam logic [LBL_W-1:0] FULL = LBL_W'(NUM_LABELS);
    localparam logic [LBL_W-1:0] ONE  = LBL_W'(1);

    fill_st_t         state_q, state_d;
    port_op_t         op;
    logic [LBL_W-1:0] depth_q, depth_d;
    logic [LBL_W-1:0] wlo_q, wlo_d;
    logic             pend_vld_q, pend_vld_d;
    logic [LBL_W-1:0] pend_lbl_q, pend_lbl_d;
    logic [LBL_W-1:0] out_lbl_q, out_lbl_d;
    logic             out_vld_q, out_vld_d;
    logic             out_err_q, out_err_d;
    logic [LBL_W-1:0] top_w;
    logic [LBL_W-1:0] fill_a;

    function automatic logic [LBL_W-1:0] seed_of(input logic [LBL_W-1:0] a);
        return FULL - a;
    endfunction

    assign top_w     = depth_q - ONE;
    assign fill_a    = wlo_q - ONE;
    assign mem_raddr = top_w[AW-1:0];

    // Port arbitration and next-state of the stack pointers
    always_comb begin
        op         = PORT_IDLE;
        depth_d    = depth_q;
        wlo_d      = wlo_q;
        pend_vld_d = pend_vld_q;
        pend_lbl_d = pend_lbl_q;
        out_lbl_d  = '0;
        out_vld_d  = 1'b0;
        out_err_d  = 1'b0;
        if (!frame_start_i) begin
            if (pop_i) begin
                out_vld_d = 1'b1;
                if (pend_vld_q) begin
                    out_lbl_d  = pend_lbl_q;
                    pend_vld_d = 1'b0;
                    if (push_i) begin
                        op      = PORT_PUSH;
                        depth_d = depth_q + ONE;
                    end
                end else if (depth_q != '0) begin
                    op        = PORT_READ;
                    out_lbl_d = (top_w >= wlo_q) ? mem_rdata : seed_of(top_w);
                    depth_d   = top_w;
                    if (top_w < wlo_q) begin
                        wlo_d = top_w;
                    end
                    if (push_i) begin
                        pend_vld_d = 1'b1;
                        pend_lbl_d = push_lbl_i;
                    end
                end else begin
                    out_err_d = 1'b1;
                    if (push_i) begin
                        op      = PORT_PUSH;
                        depth_d = depth_q + ONE;
                    end
                end
            end else if (pend_vld_q) begin
                op         = PORT_FLUSH;
                depth_d    = depth_q + ONE;
                pend_vld_d = push_i;
                pend_lbl_d = push_lbl_i;
            end else if (push_i) begin
                op      = PORT_PUSH;
                depth_d = depth_q + ONE;
            end else if (state_q == FILL_RUN && wlo_q != '0) begin
                op    = PORT_FILL;
                wlo_d = fill_a;
            end
        end
    end

    // Next refill state
    always_comb begin
        state_d = state_q;
        if (frame_start_i) begin
            state_d = FILL_RUN;
        end else begin
            unique case (state_q)
                FILL_RUN:  if (wlo_d == '0) state_d = FILL_DONE;
                FILL_DONE: state_d = FILL_DONE;
                default:   state_d = FILL_RUN;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q    <= FULL;
            wlo_q      <= FULL;
            pend_vld_q <= 1'b0;
            pend_lbl_q <= '0;
            out_lbl_q  <= '0;
            out_vld_q  <= 1'b0;
            out_err_q  <= 1'b0;
        end else if (frame_start_i) begin
            depth_q    <= FULL;
            wlo_q      <= FULL;
            pend_vld_q <= 1'b0;
            out_vld_q  <= 1'b0;
            out_err_q  <= 1'b0;
            out_lbl_q  <= '0;
        end else begin
            depth_q    <= depth_d;
            wlo_q      <= wlo_d;
            pend_vld_q <= pend_vld_d;
            pend_lbl_q <= pend_lbl_d;
            out_lbl_q  <= out_lbl_d;
            out_vld_q  <= out_vld_d;
            out_err_q  <= out_err_d;
        end
    end

    // Outputs and memory write mux
    always_comb begin
        lbl_o       = out_lbl_q;
        lbl_vld_o   = out_vld_q;
        empty_err_o = out_err_q;
        fill_busy_o = (state_q == FILL_RUN);
        mem_we      = 1'b0;
        mem_waddr   = depth_q[AW-1:0];
        mem_wdata   = push_lbl_i;
        unique case (op)
            PORT_IDLE, PORT_READ: mem_we = 1'b0;
            PORT_FLUSH: begin
                mem_we    = 1'b1;
                mem_wdata = pend_lbl_q;
            end
            PORT_PUSH: mem_we = 1'b1;
            PORT_FILL: begin
                mem_we    = 1'b1;
                mem_waddr = fill_a[AW-1:0];
                mem_wdata = seed_of(fill_a);
            end
            default: mem_we = 1'b0;
        endcase
    end

    // R2: every accepted pop is answered in the next cycle
    a_r2_pop_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !frame_start_i) |=> lbl_vld_o);

    // R4: an empty pop carries label zero
    a_r4_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        empty_err_o |-> (lbl_vld_o && lbl_o == '0));

    // R5: frame start refills pointers and drops same-cycle requests
    a_r5_frame_refill: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> (depth_q == FULL && wlo_q == FULL && !pend_vld_q && !lbl_vld_o && fill_busy_o));

    // R6: the refill pointer only moves downward within a frame
    a_r6_fill_descends: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start_i |=> (wlo_q <= $past(wlo_q)));

    // R6: refill done means no entry is left unwritten
    a_r6_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FILL_DONE) |-> (wlo_q == '0));

    // R9: the unwritten region always lies below the stack top
    a_r9_fill_below_top: assert property (@(posedge clk) disable iff (!rst_n)
        wlo_q <= depth_q);

    // R7: the refill never writes while a pop holds the port
    a_r7_pop_blocks_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !frame_start_i && !pend_vld_q && depth_q > wlo_q) |=> (wlo_q == $past(wlo_q)));

endmodule

// File: rtl/free_label_stack.sv
module free_label_stack #(
    parameter int NUM_LABELS = 256,
    localparam int LBL_W     = $clog2(NUM_LABELS + 1),
    localparam int AW        = $clog2(NUM_LABELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start_i,
    input  logic             pop_i,
    input  logic             push_i,
    input  logic [LBL_W-1:0] push_lbl_i,
    output logic [LBL_W-1:0] lbl_o,
    output logic             lbl_vld_o,
    output logic             empty_err_o,
    output logic             fill_busy_o
);

    logic             mem_we;
    logic [AW-1:0]    mem_waddr;
    logic [LBL_W-1:0] mem_wdata;
    logic [AW-1:0]    mem_raddr;
    logic [LBL_W-1:0] mem_rdata;

    flstk_ctrl #(
        .NUM_LABELS(NUM_LABELS),
        .LBL_W     (LBL_W),
        .AW        (AW)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start_i(frame_start_i),
        .pop_i        (pop_i),
        .push_i       (push_i),
        .push_lbl_i   (push_lbl_i),
        .mem_rdata    (mem_rdata),
        .mem_we       (mem_we),
        .mem_waddr    (mem_waddr),
        .mem_wdata    (mem_wdata),
        .mem_raddr    (mem_raddr),
        .lbl_o        (lbl_o),
        .lbl_vld_o    (lbl_vld_o),
        .empty_err_o  (empty_err_o),
        .fill_busy_o  (fill_busy_o)
    );

    flstk_mem #(
        .DEPTH(NUM_LABELS),
        .DW   (LBL_W),
        .AW   (AW)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr_w(mem_waddr),
        .data_w(mem_wdata),
        .addr_r(mem_raddr),
        .data_r(mem_rdata)
    );

endmodule

// File: tb/sim_free_label_stack.sv
module sim_free_label_stack;

    localparam int CLK_P = 10;
    localparam int NL    = 16;
    localparam int LW    = $clog2(NL + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start_i = 1'b0;
    logic          pop_i = 1'b0;
    logic          push_i = 1'b0;
    logic [LW-1:0] push_lbl_i = '0;
    logic [LW-1:0] lbl_o;
    logic          lbl_vld_o;
    logic          empty_err_o;
    logic          fill_busy_o;

    int total = 0;
    int bad   = 0;
    int q[$];
    int freed[$];
    string tag = "R1";

    always #(CLK_P / 2) clk = ~clk;

    free_label_stack #(.NUM_LABELS(NL)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start_i(frame_start_i),
        .pop_i        (pop_i),
        .push_i       (push_i),
        .push_lbl_i   (push_lbl_i),
        .lbl_o        (lbl_o),
        .lbl_vld_o    (lbl_vld_o),
        .empty_err_o  (empty_err_o),
        .fill_busy_o  (fill_busy_o)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_full();
        q.delete();
        freed.delete();
        for (int i = 1; i <= NL; i++) q.push_back(i);
    endtask

    task automatic step(input bit p, input bit u, input int l, input bit f);
        bit ev;
        bit ee;
        int el;
        @(negedge clk);
        pop_i         = p;
        push_i        = u;
        push_lbl_i    = LW'(l);
        frame_start_i = f;
        ev = 1'b0; ee = 1'b0; el = 0;
        if (f) begin
            model_full();
        end else begin
            ev = p;
            if (p) begin
                if (q.size() > 0) begin
                    el = q.pop_front();
                    freed.push_back(el);
                end else begin
                    ee = 1'b1;
                end
            end
            if (u) q.push_front(l);
        end
        @(posedge clk);
        #1;
        check(lbl_vld_o == ev, tag, "lbl_vld_o", int'(lbl_vld_o), int'(ev));
        if (ev) begin
            check(int'(lbl_o) == el, tag, "lbl_o", int'(lbl_o), el);
            check(empty_err_o == ee, tag, "empty_err_o", int'(empty_err_o), int'(ee));
        end
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 1'b0);
    endtask

    initial begin
        #(CLK_P * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_full();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 / R6: reset state
        check(lbl_vld_o == 1'b0, "R1", "reset lbl_vld_o", int'(lbl_vld_o), 0);
        check(fill_busy_o == 1'b1, "R6", "reset fill_busy_o", int'(fill_busy_o), 1);

        // R1 / R7: drain the whole pool right after reset, during refill
        tag = "R7";
        for (int i = 0; i < NL; i++) step(1'b1, 1'b0, 0, 1'b0);
        check(fill_busy_o == 1'b0, "R7", "busy after drain", int'(fill_busy_o), 0);

        // R4: empty pop
        tag = "R4";
        step(1'b1, 1'b0, 0, 1'b0);
        step(1'b1, 1'b0, 0, 1'b0);

        // R3: LIFO of pushes
        tag = "R3";
        step(1'b0, 1'b1, 5, 1'b0);
        step(1'b0, 1'b1, 9, 1'b0);
        step(1'b0, 1'b1, 2, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 0, 1'b0);

        // R8: pop and push together, then immediate pop of the deferred label
        tag = "R8";
        step(1'b0, 1'b1, 7, 1'b0);
        step(1'b0, 1'b1, 3, 1'b0);
        step(1'b1, 1'b1, 11, 1'b0);
        step(1'b1, 1'b0, 0, 1'b0);
        step(1'b1, 1'b1, 4, 1'b0);
        step(1'b0, 1'b1, 6, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 0, 1'b0);

        // R5: frame start with requests in the same cycle
        tag = "R5";
        step(1'b1, 1'b1, 13, 1'b1);
        check(fill_busy_o == 1'b1, "R5", "busy after frame start", int'(fill_busy_o), 1);
        // R6: exact refill duration with no traffic
        tag = "R6";
        quiet(NL - 1);
        check(fill_busy_o == 1'b1, "R6", "busy one cycle before end", int'(fill_busy_o), 1);
        quiet(1);
        check(fill_busy_o == 1'b0, "R6", "busy after NUM_LABELS cycles", int'(fill_busy_o), 0);
        tag = "R1";
        for (int i = 0; i < NL; i++) step(1'b1, 1'b0, 0, 1'b0);

        // R9: pushes during refill survive it
        tag = "R9";
        step(1'b0, 1'b0, 0, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 0, 1'b0);
        step(1'b0, 1'b1, 2, 1'b0);
        freed.delete();
        step(1'b0, 1'b1, 1, 1'b0);
        quiet(NL + 2);
        check(fill_busy_o == 1'b0, "R9", "busy after refill", int'(fill_busy_o), 0);
        for (int i = 0; i < NL; i++) step(1'b1, 1'b0, 0, 1'b0);

        // R8 / R7: random mixed traffic with occasional frame starts
        tag = "R8";
        step(1'b0, 1'b0, 0, 1'b1);
        for (int n = 0; n < 3000; n++) begin
            bit f;
            bit p;
            bit u;
            int l;
            f = ($urandom % 100) < 2;
            p = ($urandom % 3) != 0;
            u = 1'b0;
            l = 0;
            if (!f && freed.size() > 0 && q.size() < NL && ($urandom % 2) == 1) begin
                int idx;
                idx = int'($urandom % freed.size());
                l = freed[idx];
                freed.delete(idx);
                u = 1'b1;
            end
            step(p, u, l, f);
        end
        quiet(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule